// File: doc/BRIEF.md
# Boot-Time Memory Mapper and Handoff Controller

This block is the start-up glue on an 8-bit CPU bus. While the system boots it listens for two I/O control ports. Through these the CPU steers the configuration line of a companion FPGA, reads back that FPGA's status, keeps a cold-reset marker that survives warm restarts, and picks what the upper 32 KiB of its address space lands on: a ROM page or a RAM page. The low 16 KiB always selects ROM page 0 and the next 16 KiB always selects RAM page 0.

When the FPGA signals that its initialisation has finished, the block releases the memory-control lines by dropping a single output-enable (`ctl_oe`, which covers the page lines, the ROM select, both memory strobes and the FPGA select). It then pulls the system warm-reset line low for a fixed number of cycles and lets it go. From then on the FPGA owns the memory strobes. The block only folds the FPGA's four RAM selects onto two RAM chips plus one extra address line, and it keeps bridging data between the CPU bus and the memory bus. A later write of 0 to the configuration bit brings the block back into boot mapping.

Every output is registered, so each one reflects the inputs sampled at the previous rising clock edge. Tri-state pins are modelled as values with enables or pull requests; the pad ring resolves them.

Top module: `boot_mapper`

## Requirements
- R1: After `rst`: `fpga_cfg_ctl`=0, `ctl_oe`=1, `sys_rst_pull`=0, `chip_sel_n`=2'b11, `chip_xa`=0, and a read of port 0x40 returns 0x00.
- R2: An I/O write to port 0x80 (CPU address bits [7:0]) sets `fpga_cfg_ctl` to data bit 0. It is visible one cycle after the write strobe first appears.
- R3: An I/O write to port 0x80 with data bit 7 = 1 sets the cold flag. A write with bit 7 = 0 leaves it set. Only `rst` clears it.
- R4: An I/O read of port 0x80 returns {`fpga_stat_in`, 6'b0, `fpga_cfg_ok`}. An I/O read of port 0x40 returns {cold flag, 7'b0}. Both are driven on `cpu_dout` with `cpu_doe`=1.
- R5: `fpga_sel` is 1 exactly when CPU address bits [7:6] are 2'b11.
- R6: A memory request to 0x0000–0x3FFF asserts `rom_sel_n`=0 with `mem_page`=2'b00. A request to 0x4000–0x7FFF asserts `chip_sel_n[0]`=0 with `mem_page`=2'b00 and leaves the ROM deselected.
- R7: An I/O write to port 0x40 loads the map register. For 0x8000–0xFFFF, data bit 7 = 1 selects RAM (chip 0) and 0 selects ROM, and `mem_page` = {map bit 0, CPU A14}.
- R8: During any memory or I/O request, `mem_a_fwd` = {A13, A12, A11, A10, A7, A6}. With no request it holds its last value.
- R9: In boot mode, a rising edge on `fpga_boot_fin` drops `ctl_oe` in the next cycle. `sys_rst_pull` is then 1 for exactly PULL_CYC cycles (default 16) and afterwards returns to 0.
- R10: After handoff, `chip_sel_n[0]`=0 if FPGA select 0 or 1 is low, and `chip_sel_n[1]`=0 if select 2 or 3 is low. `chip_xa` is bit 0 of the lowest-numbered low select.
- R11: Before handoff, `chip_xa` stays 0 and `chip_sel_n[1]` stays 1 whatever the FPGA selects do.
- R12: While a RAM chip is selected and the write strobe is active, `mem_dout`=`cpu_din` with `mem_doe`=1. With the read strobe active instead, `cpu_dout`=`mem_din` with `cpu_doe`=1. The strobes are the CPU's in boot mode and `ext_rd_en_n`/`ext_wr_en_n` after handoff. A ROM access does not drive `cpu_doe`.
- R13: After handoff, an I/O write to port 0x80 with bit 0 = 0 returns the block to boot mode (`ctl_oe`=1). A `fpga_boot_fin` rise in that same cycle is ignored. A new handoff needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| cpu_a | input | 16 | CPU address bus |
| cpu_din | input | 8 | Data the CPU drives |
| cpu_dout | output | 8 | Data toward the CPU |
| cpu_doe | output | 1 | Drive enable for `cpu_dout` |
| cpu_mem_req_n | input | 1 | CPU memory request, active low |
| cpu_io_req_n | input | 1 | CPU I/O request, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| fpga_cfg_ctl | output | 1 | FPGA configuration control line |
| fpga_stat_in | input | 1 | FPGA status line |
| fpga_cfg_ok | input | 1 | FPGA configuration-done input |
| fpga_boot_fin | input | 1 | FPGA initialisation-finished input |
| fpga_sel | output | 1 | FPGA chip select, active high |
| ctl_oe | output | 1 | Enable for the page, ROM select, strobe and FPGA-select outputs |
| mem_page | output | 2 | Memory page address {high, low} |
| rom_sel_n | output | 1 | ROM select, active low |
| mem_rd_en_n | output | 1 | Memory output-enable strobe |
| mem_wr_en_n | output | 1 | Memory write strobe |
| mem_a_fwd | output | 6 | Forwarded address {A13..A10, A7, A6} |
| ext_rd_en_n | input | 1 | Read strobe seen on the memory bus after handoff |
| ext_wr_en_n | input | 1 | Write strobe seen on the memory bus after handoff |
| fpga_ram_sel_n | input | 4 | Four RAM selects from the FPGA, active low |
| chip_sel_n | output | 2 | RAM chip selects, active low |
| chip_xa | output | 1 | Extra RAM address line |
| mem_din | input | 8 | Data from memory |
| mem_dout | output | 8 | Data toward memory |
| mem_doe | output | 1 | Drive enable for `mem_dout` |
| sys_rst_pull | output | 1 | 1 pulls the warm-reset line low |

## Verification
The two functions that can meet in one cycle are the handoff trigger and the return to boot. A new rising edge on `fpga_boot_fin` can arrive in the same cycle as a port-0x80 write of bit 0 = 0. The bench provokes this while in run mode: it first lowers `fpga_boot_fin`, then raises it in the same cycle as the CPU write. The return must win, so `ctl_oe` goes back to 1, `sys_rst_pull` stays 0, and neither changes over the following cycles while `fpga_boot_fin` stays high. After that the bench gives a fresh edge, and the handoff must start again with the full pull length.

// File: rtl/boot_pkg.sv
package boot_pkg;
  // Handoff sequence: boot mapping, warm-reset pull, FPGA-owned run mode
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_PULL = 2'd1,
    ST_RUN  = 2'd2
  } hand_st_t;

  // Registered memory-control bundle produced by the map decoder
  typedef struct packed {
    logic [1:0] page;
    logic       rom_n;
    logic       rd_n;
    logic       wr_n;
    logic       fsel;
  } mem_ctl_t;
endpackage

// File: rtl/boot_ctl_regs.sv
module boot_ctl_regs #(
  parameter int         DW        = 8,
  parameter logic [7:0] CTRL_PORT = 8'h80,
  parameter logic [7:0] MAP_PORT  = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    port,
  input  logic [DW-1:0] din,
  input  logic          io_req_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          stat_in,
  input  logic          ok_in,
  input  logic          run,
  output logic          cfg_ctl,
  output logic          cold_flag,
  output logic          map_ram,
  output logic          map_pg,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic          leave_run
);
  localparam int TOP = DW - 1;

  logic wr_now, wr_seen, wr_pulse, hit_ctrl, hit_map;
  logic unused_mid;

  assign unused_mid = ^din[TOP-1:1];
  assign hit_ctrl   = (port == CTRL_PORT);
  assign hit_map    = (port == MAP_PORT);
  assign wr_now     = !io_req_n && !wr_n;
  assign wr_pulse   = wr_now && !wr_seen;   // one update per write access

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen   <= 1'b0;
      cfg_ctl   <= 1'b0;
      cold_flag <= 1'b0;
      map_ram   <= 1'b0;
      map_pg    <= 1'b0;
    end else begin
      wr_seen <= wr_now;
      if (wr_pulse && hit_ctrl) begin
        cfg_ctl <= din[0];
        if (din[TOP]) cold_flag <= 1'b1;   // sticky until cold reset
      end
      if (wr_pulse && hit_map) begin
        map_ram <= din[TOP];
        map_pg  <= din[0];
      end
    end
  end

  assign leave_run = run && wr_pulse && hit_ctrl && !din[0];

  always_comb begin
    rd_hit  = !io_req_n && !rd_n && (hit_ctrl || hit_map);
    rd_data = '0;
    if (hit_ctrl) begin
      rd_data[TOP] = stat_in;
      rd_data[0]   = ok_in;
    end else if (hit_map) begin
      rd_data[TOP] = cold_flag;
    end
  end

  // R3: once set, the cold flag never drops without reset
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    cold_flag |=> cold_flag);

  // R2: configuration line follows bit 0 of the write
  a_r2_cfg_follows: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse && hit_ctrl) |=> (cfg_ctl == $past(din[0])));

  // R7: map register changes only on a write to its port
  a_r7_map_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_pulse && hit_map) |=> ($stable(map_pg) && $stable(map_ram)));
endmodule

// File: rtl/boot_mem_map.sv
module boot_mem_map
  import boot_pkg::*;
#(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    hi_a,     // CPU A15, A14
  input  logic [FW-1:0] mid_a,    // CPU A13..A10, A7, A6
  input  logic [1:0]    sel_a,    // CPU A7, A6
  input  logic          mem_req_n,
  input  logic          io_req_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          map_ram,
  input  logic          map_pg,
  output mem_ctl_t      ctl,
  output logic [FW-1:0] fwd_a,
  output logic          ram0_req
);
  logic       mem_act, upper, rom_zone;
  logic [1:0] page_nxt;
  mem_ctl_t   ctl_nxt;

  always_comb begin
    mem_act  = !mem_req_n;
    upper    = hi_a[1];
    rom_zone = upper ? !map_ram : !hi_a[0];
    page_nxt = upper ? {map_pg, hi_a[0]} : 2'b00;
    ram0_req = mem_act && !rom_zone;
    ctl_nxt.page  = page_nxt;
    ctl_nxt.rom_n = !(mem_act && rom_zone);
    ctl_nxt.rd_n  = !(mem_act && !rd_n);
    ctl_nxt.wr_n  = !(mem_act && !wr_n);
    ctl_nxt.fsel  = &sel_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '{page: 2'b00, rom_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, fsel: 1'b0};
      fwd_a <= '0;
    end else begin
      ctl <= ctl_nxt;
      if (mem_act || !io_req_n) fwd_a <= mid_a;
    end
  end

  // R6: the lowest window always reaches ROM page 0
  a_r6_low_rom: assert property (@(posedge clk) disable iff (rst)
    (!mem_req_n && hi_a == 2'b00) |=> (!ctl.rom_n && ctl.page == 2'b00));

  // R5: FPGA select decode
  a_r5_fsel: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b11) |=> ctl.fsel);

  // R8: forwarded address holds between requests
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_n && io_req_n) |=> $stable(fwd_a));
endmodule

// File: rtl/boot_handoff.sv
module boot_handoff
  import boot_pkg::*;
#(
  parameter int PULL_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fin,
  input  logic leave,
  output logic ctl_oe,
  output logic pull,
  output logic run
);
  localparam int CW = $clog2(PULL_CYC + 1);

  hand_st_t st;
  logic [CW-1:0] cnt;
  logic fin_q, fin_rise;

  assign fin_rise = fin && !fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_BOOT;
      cnt   <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin;
      unique case (st)
        ST_BOOT: if (fin_rise) begin
          st  <= ST_PULL;
          cnt <= '0;
        end
        ST_PULL: if (cnt == CW'(PULL_CYC - 1)) st <= ST_RUN;
                 else cnt <= cnt + 1'b1;
        ST_RUN:  if (leave) st <= ST_BOOT;
        default: st <= ST_BOOT;
      endcase
    end
  end

  assign ctl_oe = (st == ST_BOOT);
  assign pull   = (st == ST_PULL);
  assign run    = (st == ST_RUN);

  // Checker counter for the pull window length
  logic [CW-1:0] pull_len;
  always_ff @(posedge clk) begin
    if (rst || !pull) pull_len <= '0;
    else              pull_len <= pull_len + 1'b1;
  end

  // R9: pull never exceeds its length and always lasts the full length
  a_r9_pull_bound: assert property (@(posedge clk) disable iff (rst)
    pull |-> (pull_len <= CW'(PULL_CYC - 1)));
  a_r9_pull_full: assert property (@(posedge clk) disable iff (rst)
    $fell(pull) |-> ($past(pull_len) == CW'(PULL_CYC - 1)));
  a_r9_oe_drop: assert property (@(posedge clk) disable iff (rst)
    (ctl_oe && fin_rise) |=> (!ctl_oe && pull));

  // R13: a return request in run mode wins over a new trigger
  a_r13_back: assert property (@(posedge clk) disable iff (rst)
    (run && leave) |=> (ctl_oe && !pull));
endmodule

// File: rtl/boot_cs_fold.sv
module boot_cs_fold #(
  parameter int NSEL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [NSEL-1:0] sel_n,
  input  logic            boot_req,
  output logic [NSEL/2-1:0] cs_n,
  output logic            xa,
  output logic            any_nxt
);
  localparam int NCH = NSEL / 2;

  logic [NCH-1:0] act;
  logic [NCH-1:0] cs_nxt;
  logic xa_f, xa_nxt;

  for (genvar j = 0; j < NCH; j++) begin : g_pair
    assign act[j] = !sel_n[2*j] || !sel_n[2*j+1];
  end

  always_comb begin
    xa_f = 1'b0;
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (!sel_n[i]) xa_f = i[0];   // lowest active index wins
    end
    if (run) begin
      cs_nxt = ~act;
      xa_nxt = xa_f;
    end else begin
      cs_nxt    = '1;
      cs_nxt[0] = !boot_req;
      xa_nxt    = 1'b0;
    end
    any_nxt = |(~cs_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= '1;
      xa   <= 1'b0;
    end else begin
      cs_n <= cs_nxt;
      xa   <= xa_nxt;
    end
  end

  // R11: outside run mode the second chip and extra line stay idle
  a_r11_boot_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cs_n[NCH-1] && !xa));

  // R10: a lone select 0 reaches chip 0 with the extra line low
  a_r10_sel0: assert property (@(posedge clk) disable iff (rst)
    (run && sel_n == ~NSEL'(1)) |=> (!cs_n[0] && !xa));
endmodule

// File: rtl/boot_mapper.sv
module boot_mapper
  import boot_pkg::*;
#(
  parameter int         DW        = 8,
  parameter int         NSEL      = 4,
  parameter int         PULL_CYC  = 16,
  parameter logic [7:0] CTRL_PORT = 8'h80,
  parameter logic [7:0] MAP_PORT  = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_a,
  input  logic [DW-1:0]     cpu_din,
  output logic [DW-1:0]     cpu_dout,
  output logic              cpu_doe,
  input  logic              cpu_mem_req_n,
  input  logic              cpu_io_req_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  output logic              fpga_cfg_ctl,
  input  logic              fpga_stat_in,
  input  logic              fpga_cfg_ok,
  input  logic              fpga_boot_fin,
  output logic              fpga_sel,
  output logic              ctl_oe,
  output logic [1:0]        mem_page,
  output logic              rom_sel_n,
  output logic              mem_rd_en_n,
  output logic              mem_wr_en_n,
  output logic [5:0]        mem_a_fwd,
  input  logic              ext_rd_en_n,
  input  logic              ext_wr_en_n,
  input  logic [NSEL-1:0]   fpga_ram_sel_n,
  output logic [NSEL/2-1:0] chip_sel_n,
  output logic              chip_xa,
  input  logic [DW-1:0]     mem_din,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_doe,
  output logic              sys_rst_pull
);
  localparam int FW = 6;

  logic          cold_flag, map_ram, map_pg, rd_hit, leave_run;
  logic [DW-1:0] rd_data;
  logic          run, ram0_req, any_nxt;
  logic          oe_act, we_act;
  logic          unused_a;
  mem_ctl_t      ctl;

  assign unused_a = ^cpu_a[9:8];

  boot_ctl_regs #(.DW(DW), .CTRL_PORT(CTRL_PORT), .MAP_PORT(MAP_PORT)) u_regs (
    .clk(clk), .rst(rst), .port(cpu_a[7:0]), .din(cpu_din),
    .io_req_n(cpu_io_req_n), .rd_n(cpu_rd_n), .wr_n(cpu_wr_n),
    .stat_in(fpga_stat_in), .ok_in(fpga_cfg_ok), .run(run),
    .cfg_ctl(fpga_cfg_ctl), .cold_flag(cold_flag), .map_ram(map_ram),
    .map_pg(map_pg), .rd_hit(rd_hit), .rd_data(rd_data), .leave_run(leave_run)
  );

  boot_mem_map #(.FW(FW)) u_map (
    .clk(clk), .rst(rst), .hi_a(cpu_a[15:14]),
    .mid_a({cpu_a[13:10], cpu_a[7:6]}), .sel_a(cpu_a[7:6]),
    .mem_req_n(cpu_mem_req_n), .io_req_n(cpu_io_req_n),
    .rd_n(cpu_rd_n), .wr_n(cpu_wr_n), .map_ram(map_ram), .map_pg(map_pg),
    .ctl(ctl), .fwd_a(mem_a_fwd), .ram0_req(ram0_req)
  );

  boot_handoff #(.PULL_CYC(PULL_CYC)) u_hand (
    .clk(clk), .rst(rst), .fin(fpga_boot_fin), .leave(leave_run),
    .ctl_oe(ctl_oe), .pull(sys_rst_pull), .run(run)
  );

  boot_cs_fold #(.NSEL(NSEL)) u_fold (
    .clk(clk), .rst(rst), .run(run), .sel_n(fpga_ram_sel_n),
    .boot_req(ram0_req), .cs_n(chip_sel_n), .xa(chip_xa), .any_nxt(any_nxt)
  );

  assign mem_page    = ctl.page;
  assign rom_sel_n   = ctl.rom_n;
  assign mem_rd_en_n = ctl.rd_n;
  assign mem_wr_en_n = ctl.wr_n;
  assign fpga_sel    = ctl.fsel;

  // Data bridge: strobes come from the CPU in boot mode, from the memory bus after
  assign oe_act = run ? !ext_rd_en_n : (!cpu_mem_req_n && !cpu_rd_n);
  assign we_act = run ? !ext_wr_en_n : (!cpu_mem_req_n && !cpu_wr_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_doe  <= 1'b0;
      mem_dout <= '0;
      cpu_doe  <= 1'b0;
      cpu_dout <= '0;
    end else begin
      mem_doe  <= any_nxt && we_act;
      mem_dout <= cpu_din;
      cpu_doe  <= rd_hit || (any_nxt && oe_act);
      cpu_dout <= rd_hit ? rd_data : mem_din;
    end
  end

  // R12: a ROM-only access never drives the CPU data bus from memory
  a_r12_rom_no_bridge: assert property (@(posedge clk) disable iff (rst)
    (!run && !cpu_mem_req_n && !cpu_a[14] && !cpu_a[15] && cpu_io_req_n) |=> !cpu_doe);

  // R6: ROM and RAM chip 0 are never selected together in boot mode
  a_r6_excl: assert property (@(posedge clk) disable iff (rst)
    ctl_oe |-> $onehot0({!rom_sel_n, !chip_sel_n[0]}));
endmodule

// File: tb/tb_boot_mapper.sv
`timescale 1ns/1ps
module tb_boot_mapper;
  localparam int PULL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cpu_a = '0;
  logic [7:0]  cpu_din = '0, cpu_dout, mem_din = '0, mem_dout;
  logic cpu_doe, mem_doe;
  logic mreq_n = 1, ioreq_n = 1, rd_n = 1, wr_n = 1;
  logic cfg_ctl, stat_in = 1'b0, cfg_ok = 1'b0, fin = 1'b0;
  logic fsel, ctl_oe, rom_n, rd_en_n, wr_en_n, xa, pull;
  logic [1:0] page, cs_n;
  logic [5:0] fwd;
  logic ext_rd_n = 1, ext_wr_n = 1;
  logic [3:0] sel_n = 4'hF;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  boot_mapper #(.PULL_CYC(PULL)) dut (
    .clk(clk), .rst(rst), .cpu_a(cpu_a), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
    .cpu_doe(cpu_doe), .cpu_mem_req_n(mreq_n), .cpu_io_req_n(ioreq_n),
    .cpu_rd_n(rd_n), .cpu_wr_n(wr_n), .fpga_cfg_ctl(cfg_ctl),
    .fpga_stat_in(stat_in), .fpga_cfg_ok(cfg_ok), .fpga_boot_fin(fin),
    .fpga_sel(fsel), .ctl_oe(ctl_oe), .mem_page(page), .rom_sel_n(rom_n),
    .mem_rd_en_n(rd_en_n), .mem_wr_en_n(wr_en_n), .mem_a_fwd(fwd),
    .ext_rd_en_n(ext_rd_n), .ext_wr_en_n(ext_wr_n), .fpga_ram_sel_n(sel_n),
    .chip_sel_n(cs_n), .chip_xa(xa), .mem_din(mem_din), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .sys_rst_pull(pull)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    mreq_n = 1; ioreq_n = 1; rd_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic io_wr(input logic [7:0] port, input logic [7:0] d);
    cpu_a = {8'h00, port}; cpu_din = d; ioreq_n = 0; wr_n = 0;
    @(negedge clk);
    idle();
  endtask

  task automatic io_rd(input logic [7:0] port, output logic [7:0] d, output logic oe);
    cpu_a = {8'h00, port}; ioreq_n = 0; rd_n = 0;
    @(negedge clk);
    d = cpu_dout; oe = cpu_doe;
    idle();
  endtask

  // leaves the strobes active; caller checks then calls idle()
  task automatic mem_op(input logic [15:0] a, input logic wr);
    cpu_a = a; mreq_n = 0; rd_n = wr; wr_n = !wr;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    chk("R1 cfg_ctl", cfg_ctl, 0);
    chk("R1 ctl_oe", ctl_oe, 1);
    chk("R1 pull", pull, 0);
    chk("R1 chip_sel_n", cs_n, 2'b11);
    chk("R1 chip_xa", xa, 0);
    io_rd(8'h40, d, oe);
    chk("R1 flag read", {oe, d}, 9'h100);
  endtask

  task automatic t_cfg();
    io_wr(8'h80, 8'h01);
    chk("R2 cfg high", cfg_ctl, 1);
    io_wr(8'h80, 8'h00);
    chk("R2 cfg low", cfg_ctl, 0);
  endtask

  task automatic t_status();
    logic [7:0] d; logic oe;
    stat_in = 0; cfg_ok = 1;
    io_rd(8'h80, d, oe);
    chk("R4 status read a", {oe, d}, 9'h101);
    stat_in = 1; cfg_ok = 0;
    io_rd(8'h80, d, oe);
    chk("R4 status read b", {oe, d}, 9'h180);
  endtask

  task automatic t_flag();
    logic [7:0] d; logic oe;
    io_wr(8'h80, 8'h81);
    io_rd(8'h40, d, oe);
    chk("R3 flag set", d, 8'h80);
    io_wr(8'h80, 8'h01);
    io_rd(8'h40, d, oe);
    chk("R3 flag sticky", d, 8'h80);
    chk("R2 cfg kept", cfg_ctl, 1);
  endtask

  task automatic t_fsel();
    for (int i = 0; i < 4; i++) begin
      cpu_a = {8'h00, i[1:0], 6'h00};
      @(negedge clk);
      chk("R5 fpga_sel", fsel, (i == 3));
    end
  endtask

  task automatic t_map();
    mem_op(16'h0123, 0);
    chk("R6 low rom", {rom_n, cs_n[0], page, rd_en_n, wr_en_n}, 6'b010001);
    idle();
    mem_op(16'h4567, 1);
    chk("R6 low ram", {rom_n, cs_n[0], page, rd_en_n, wr_en_n}, 6'b100010);
    idle();
    for (int i = 0; i < 4; i++) begin
      io_wr(8'h40, {7'd0, i[1]});
      mem_op({1'b1, i[0], 14'h0aa0}, 0);
      chk("R7 upper rom", {rom_n, cs_n[0], page}, {2'b01, i[1], i[0]});
      idle();
    end
    io_wr(8'h40, 8'h81);
    mem_op(16'hC000, 0);
    chk("R7 upper ram", {rom_n, cs_n[0], page}, 4'b1011);
    idle();
    io_wr(8'h40, 8'h80);
    mem_op(16'h8000, 0);
    chk("R7 upper ram pg0", {rom_n, cs_n[0], page}, 4'b1000);
    idle();
  endtask

  task automatic t_fwd();
    mem_op(16'h3CC0, 0);
    chk("R8 fwd mem", fwd, 6'b111111);
    idle();
    cpu_a = 16'h0000;
    @(negedge clk);
    chk("R8 fwd hold", fwd, 6'b111111);
    cpu_a = 16'h0440; ioreq_n = 0; rd_n = 0;
    @(negedge clk);
    chk("R8 fwd io", fwd, 6'b000101);
    idle();
  endtask

  task automatic t_bridge_boot();
    cpu_din = 8'h5A;
    mem_op(16'h4000, 1);
    chk("R12 boot write", {mem_doe, mem_dout}, 9'h15A);
    idle();
    mem_din = 8'hA5;
    mem_op(16'h4000, 0);
    chk("R12 boot read", {cpu_doe, cpu_dout}, 9'h1A5);
    idle();
    mem_op(16'h0000, 0);
    chk("R12 rom no bridge", cpu_doe, 0);
    idle();
  endtask

  task automatic t_handoff();
    int cnt;
    sel_n = 4'h0;
    mem_op(16'h4000, 0);
    chk("R11 boot fold", {cs_n, xa}, 3'b100);
    idle();
    fin = 1;
    @(negedge clk);
    chk("R9 oe drop", {ctl_oe, pull}, 2'b01);
    cnt = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!pull) break;
      cnt++;
    end
    chk("R9 pull length", cnt, PULL);
    chk("R9 released", {ctl_oe, pull}, 2'b00);
  endtask

  task automatic t_fold();
    for (int i = 0; i < 4; i++) begin
      sel_n = ~(4'b0001 << i);
      @(negedge clk);
      chk("R10 fold single", {cs_n, xa}, {!i[1], i[1], i[0]});
    end
    sel_n = 4'b1001;
    @(negedge clk);
    chk("R10 fold two", {cs_n, xa}, 3'b001);
    sel_n = 4'hF;
    @(negedge clk);
    chk("R10 fold none", {cs_n, xa}, 3'b110);
  endtask

  task automatic t_bridge_run();
    sel_n = 4'b1110; ext_rd_n = 0; mem_din = 8'h3C;
    @(negedge clk);
    chk("R12 run read", {cpu_doe, cpu_dout}, 9'h13C);
    ext_rd_n = 1; ext_wr_n = 0; cpu_din = 8'hC3;
    @(negedge clk);
    chk("R12 run write", {mem_doe, mem_dout, cpu_doe}, 10'b1_1100_0011_0);
    ext_wr_n = 1; sel_n = 4'hF;
    @(negedge clk);
  endtask

  task automatic t_collide();
    fin = 0;
    @(negedge clk);
    chk("R13 still run", ctl_oe, 0);
    fin = 1; cpu_a = 16'h0080; cpu_din = 8'h00; ioreq_n = 0; wr_n = 0;
    @(negedge clk);
    chk("R13 return wins", {ctl_oe, pull}, 2'b10);
    idle();
    repeat (3) @(negedge clk);
    chk("R13 no late handoff", {ctl_oe, pull, cfg_ctl}, 3'b100);
    sel_n = 4'h0;
    @(negedge clk);
    chk("R11 back to boot", {cs_n, xa}, 3'b110);
    sel_n = 4'hF;
    fin = 0;
    @(negedge clk);
    fin = 1;
    @(negedge clk);
    chk("R9 fresh edge", {ctl_oe, pull}, 2'b01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_status();
    t_flag();
    t_fsel();
    t_map();
    t_fwd();
    t_bridge_boot();
    t_handoff();
    t_fold();
    t_bridge_run();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule